// File: doc/BRIEF.md
# Nonvolatile Memory Command Launch and Status Register

This block is the software-facing status register of a nonvolatile memory command engine, together with the interlock that decides when a command may start. Software starts a command by writing 1 to the completion flag, which clears the flag and sends a one-cycle start pulse to the engine. The flag stays at 0 while the command runs and returns to 1 when the engine reports completion, or when a command violation ends the command early.

Two sticky error flags record access errors (a broken command write sequence or an illegal command) and protection violations (a program or erase aimed at a protected address). While either flag is set, no command can be launched. A two-bit completion-status field holds the error class the engine reports at the end of a command. All flags are cleared by writing 1 to them. The busy bit is read-only and shows the engine's active state only while a command is in progress. The engine, the protection range checks and the command decoding sit outside this block and deliver their results as single-cycle event pulses.

Top module: `nvmc_launch_stat`

## Requirements
- R1: After reset the register reads 0x80 (completion bit 7 = 1, every other bit 0), and `cmd_start` is low.
- R2: A write to the register with bit 7 = 1 while bit 7 reads 1 and no error flag is set is a launch. Bit 7 then reads 0, bits 1:0 are cleared, and `cmd_start` is high for exactly one cycle, in the cycle after the write.
- R3: While the access-error flag (bit 5) is set, writing 1 to bit 7 leaves bit 7 at 1 and produces no `cmd_start`.
- R4: While the protection-violation flag (bit 4) is set, writing 1 to bit 7 leaves bit 7 at 1 and produces no `cmd_start`.
- R5: A `seq_err_evt` pulse sets bit 5 and a `prot_err_evt` pulse sets bit 4. If either pulse arrives in the same cycle as a launch write, the matching flag is set, bit 7 stays 1 and no `cmd_start` is issued.
- R6: Bits 5, 4, 1 and 0 are each cleared by writing 1 to that bit. Writing 0 leaves the bit unchanged. A set event in the same cycle as a clear write wins, and the bit stays 1.
- R7: An `eng_done` pulse while bit 7 reads 0 sets bit 7 and loads `eng_err` into bits 1:0. An `eng_done` pulse while bit 7 reads 1 is ignored.
- R8: A `seq_err_evt` pulse while a command is in progress ends the command: bit 7 and bit 5 both read 1.
- R9: Bit 3 reads `eng_busy` while bit 7 reads 0, and reads 0 while bit 7 reads 1.
- R10: Bits 6 and 2 always read 0. A read at any address other than `REG_OFS` returns 0, and a write at any other address has no effect.
- R11: Writing 1 to bit 7 while a command is in progress produces no second `cmd_start` and leaves bit 7 at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data; 0 unless selected at `REG_OFS` |
| cmd_start | output | 1 | One-cycle pulse that starts the command engine |
| eng_busy | input | 1 | Engine active-state level |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 2 | Completion error class, valid with `eng_done` |
| seq_err_evt | input | 1 | Access-error event pulse |
| prot_err_evt | input | 1 | Protection-violation event pulse |

## Verification
The launch is tried in four situations, which tell a real launch apart from a blocked one: from a clean idle state, with each sticky error flag already set, with an error event arriving in the same cycle as the launch write, and while a command is already running. The write-1-to-clear fields are written with 1 and with 0, and with a clear that coincides with a set event, to show which action has priority. Completion is driven both while a command runs and while the engine is idle, to show that the error-class capture depends on the in-progress state. A behavioural model of the register is compared with `reg_rdata` and `cmd_start` on every clock.

// File: rtl/nvmc_pkg.sv
package nvmc_pkg;
    localparam int DATA_W    = 8;
    localparam int B_DONE    = 7;
    localparam int B_ACCERR  = 5;
    localparam int B_PROTERR = 4;
    localparam int B_BUSY    = 3;
    localparam int STAT_W    = 2;

    typedef struct packed {
        logic              done;
        logic              acc_err;
        logic              prot_err;
        logic [STAT_W-1:0] stat;
        logic              start;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{done: 1'b1, acc_err: 1'b0, prot_err: 1'b0,
                                       stat: '0, start: 1'b0};
endpackage

// File: rtl/nvmc_reg_decode.sv
module nvmc_reg_decode
    import nvmc_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int REG_OFS = 7
) (
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              rd_hit,
    output logic              launch_req,
    output logic              clr_acc,
    output logic              clr_prot,
    output logic [STAT_W-1:0] clr_stat
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

    logic addr_hit;
    logic wr_hit;

    always_comb begin
        addr_hit   = reg_sel && (reg_addr == OFS);
        wr_hit     = addr_hit && reg_we;
        rd_hit     = addr_hit;
        launch_req = wr_hit && reg_wdata[B_DONE];
        clr_acc    = wr_hit && reg_wdata[B_ACCERR];
        clr_prot   = wr_hit && reg_wdata[B_PROTERR];
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_stat_clr
        assign clr_stat[i] = wr_hit && reg_wdata[i];
    end
endmodule

// File: rtl/nvmc_flag_core.sv
module nvmc_flag_core
    import nvmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_req,
    input  logic              clr_acc,
    input  logic              clr_prot,
    input  logic [STAT_W-1:0] clr_stat,
    input  logic              eng_done,
    input  logic [STAT_W-1:0] eng_err,
    input  logic              seq_err_evt,
    input  logic              prot_err_evt,
    output flags_t            flags_q
);
    flags_t flags_d;
    logic   blocked;
    logic   launch_ok;
    logic   finish;

    always_comb begin
        flags_d = flags_q;

        // launch interlock: any sticky or same-cycle error vetoes the start
        blocked   = flags_q.acc_err || flags_q.prot_err || seq_err_evt || prot_err_evt;
        launch_ok = launch_req && flags_q.done && !blocked;
        finish    = !flags_q.done && (eng_done || seq_err_evt);

        // sticky error flags: clear by write-1, set event wins
        if (clr_acc)      flags_d.acc_err  = 1'b0;
        if (seq_err_evt)  flags_d.acc_err  = 1'b1;
        if (clr_prot)     flags_d.prot_err = 1'b0;
        if (prot_err_evt) flags_d.prot_err = 1'b1;

        // completion status: write-1-clear, engine load, launch clear
        flags_d.stat = flags_q.stat & ~clr_stat;
        if (eng_done && !flags_q.done) flags_d.stat = eng_err;
        if (launch_ok)                 flags_d.stat = '0;

        // completion flag
        if (launch_ok) flags_d.done = 1'b0;
        if (finish)    flags_d.done = 1'b1;

        flags_d.start = launch_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= FLAGS_RESET;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/nvmc_read_mux.sv
module nvmc_read_mux
    import nvmc_pkg::*;
(
    input  logic              rd_hit,
    input  flags_t            flags_q,
    input  logic              eng_busy,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] image;

    always_comb begin
        image            = '0;
        image[B_DONE]    = flags_q.done;
        image[B_ACCERR]  = flags_q.acc_err;
        image[B_PROTERR] = flags_q.prot_err;
        image[B_BUSY]    = eng_busy && !flags_q.done;
        image[STAT_W-1:0] = flags_q.stat;
        rdata            = rd_hit ? image : '0;
    end
endmodule

// File: rtl/nvmc_launch_stat.sv
module nvmc_launch_stat
    import nvmc_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int REG_OFS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              cmd_start,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [1:0]        eng_err,
    input  logic              seq_err_evt,
    input  logic              prot_err_evt
);
    logic              rd_hit;
    logic              launch_req;
    logic              clr_acc;
    logic              clr_prot;
    logic [STAT_W-1:0] clr_stat;
    flags_t            flags_q;
    logic              st_done;
    logic              st_acc;
    logic              st_prot;

    nvmc_reg_decode #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_dec (
        .reg_sel    (reg_sel),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .rd_hit     (rd_hit),
        .launch_req (launch_req),
        .clr_acc    (clr_acc),
        .clr_prot   (clr_prot),
        .clr_stat   (clr_stat)
    );

    nvmc_flag_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_req   (launch_req),
        .clr_acc      (clr_acc),
        .clr_prot     (clr_prot),
        .clr_stat     (clr_stat),
        .eng_done     (eng_done),
        .eng_err      (eng_err),
        .seq_err_evt  (seq_err_evt),
        .prot_err_evt (prot_err_evt),
        .flags_q      (flags_q)
    );

    nvmc_read_mux u_rmux (
        .rd_hit   (rd_hit),
        .flags_q  (flags_q),
        .eng_busy (eng_busy),
        .rdata    (reg_rdata)
    );

    assign cmd_start = flags_q.start;
    assign st_done   = flags_q.done;
    assign st_acc    = flags_q.acc_err;
    assign st_prot   = flags_q.prot_err;
endmodule

// File: rtl/nvmc_launch_stat_chk.sv
module nvmc_launch_stat_chk #(
    parameter int ADDR_W  = 4,
    parameter int REG_OFS = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              cmd_start,
    input logic              st_done,
    input logic              st_acc,
    input logic              st_prot
);
    logic wr_hit;
    assign wr_hit = reg_sel && reg_we && (reg_addr == ADDR_W'(REG_OFS));

    p_start_drops_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> !st_done);

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);

    p_acc_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_acc && wr_hit && reg_wdata[7]) |=> !cmd_start);

    p_prot_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_prot && wr_hit && reg_wdata[7]) |=> !cmd_start);

    p_acc_w0_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_acc && wr_hit && !reg_wdata[5]) |=> st_acc);

    p_busy_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[3] |-> !reg_rdata[7]);

    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[6] == 1'b0) && (reg_rdata[2] == 1'b0));

    p_no_relaunch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_done && wr_hit && reg_wdata[7]) |=> !cmd_start);
endmodule

bind nvmc_launch_stat nvmc_launch_stat_chk #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cmd_start (cmd_start),
    .st_done   (st_done),
    .st_acc    (st_acc),
    .st_prot   (st_prot)
);

// File: tb/test_nvmc_launch_stat.sv
module test_nvmc_launch_stat;
    localparam int AW  = 4;
    localparam int OFS = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_sel = 1'b0, reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          cmd_start;
    logic          eng_busy = 1'b0, eng_done = 1'b0;
    logic [1:0]    eng_err = '0;
    logic          seq_err_evt = 1'b0, prot_err_evt = 1'b0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    nvmc_launch_stat #(.ADDR_W(AW), .REG_OFS(OFS)) i_nvmc_launch_stat (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_start(cmd_start), .eng_busy(eng_busy), .eng_done(eng_done),
        .eng_err(eng_err), .seq_err_evt(seq_err_evt), .prot_err_evt(prot_err_evt)
    );

    // behavioural reference model
    int m_done = 1, m_acc = 0, m_prot = 0, m_stat = 0, m_start = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_done = 1; m_acc = 0; m_prot = 0; m_stat = 0; m_start = 0;
        end else begin
            int hit, go, nd, na, np, ns;
            hit = (reg_sel && reg_we && reg_addr == OFS) ? 1 : 0;
            go  = (hit && reg_wdata[7] && m_done && !m_acc && !m_prot
                   && !seq_err_evt && !prot_err_evt) ? 1 : 0;
            na = m_acc;  if (hit && reg_wdata[5]) na = 0; if (seq_err_evt)  na = 1;
            np = m_prot; if (hit && reg_wdata[4]) np = 0; if (prot_err_evt) np = 1;
            ns = m_stat; if (hit) ns = ns & ~int'(reg_wdata[1:0]);
            if (eng_done && !m_done) ns = int'(eng_err);
            if (go) ns = 0;
            nd = m_done; if (go) nd = 0;
            if (!m_done && (eng_done || seq_err_evt)) nd = 1;
            m_done = nd; m_acc = na; m_prot = np; m_stat = ns; m_start = go;
        end
    end

    function automatic logic [7:0] model_rd();
        logic [7:0] v;
        v = 8'h00;
        if (reg_sel && reg_addr == OFS) begin
            v[7] = m_done[0]; v[5] = m_acc[0]; v[4] = m_prot[0];
            v[3] = eng_busy && !m_done; v[1:0] = m_stat[1:0];
        end
        return v;
    endfunction

    always @(negedge clk) begin
        logic [7:0] e;
        if (!finished) begin
            e = model_rd();
            n_chk++;
            if (reg_rdata !== e || cmd_start !== m_start[0]) begin
                n_bad++;
                $display("FAIL %s model cyc=%0d act rd=%h st=%b exp rd=%h st=%b",
                         (cmd_start !== m_start[0] || reg_rdata[7] !== e[7]) ? "R2" :
                         (reg_rdata[5] !== e[5]) ? "R3" : (reg_rdata[4] !== e[4]) ? "R4" :
                         (reg_rdata[3] !== e[3]) ? "R9" : (reg_rdata[1:0] !== e[1:0]) ? "R7" : "R10",
                         cyc, reg_rdata, cmd_start, e, m_start[0]);
            end
        end
    end

    task automatic report();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog act=%0d exp<=20000", cyc);
            report();
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                      input logic acc = 1'b0, input logic prot = 1'b0);
        @(posedge clk); #2;
        reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        seq_err_evt = acc; prot_err_evt = prot;
        @(posedge clk); #2;
        reg_sel = 0; reg_we = 0; reg_wdata = 0; seq_err_evt = 0; prot_err_evt = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        @(posedge clk); #2;
        reg_sel = 1; reg_we = 0; reg_addr = a;
        #1 check(reg_rdata, exp, req);
        #1 reg_sel = 0;
    endtask

    task automatic pulse(input logic done, input logic [1:0] err,
                         input logic acc, input logic prot);
        @(posedge clk); #2;
        eng_done = done; eng_err = err; seq_err_evt = acc; prot_err_evt = prot;
        @(posedge clk); #2;
        eng_done = 0; eng_err = 0; seq_err_evt = 0; prot_err_evt = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 reg_sel = 1; reg_addr = OFS[AW-1:0];
        #1 check(reg_rdata, 8'h80, "R1"); check({7'd0, cmd_start}, 8'h00, "R1");
        reg_sel = 0;
        #1 rst_n = 1;
        rd(OFS, 8'h80, "R1");

        // clean launch
        wr(OFS, 8'h80);
        check({7'd0, cmd_start}, 8'h01, "R2");
        eng_busy = 1;
        @(posedge clk); #2 check({7'd0, cmd_start}, 8'h00, "R2");
        rd(OFS, 8'h08, "R9");
        wr(OFS, 8'h80);
        check({7'd0, cmd_start}, 8'h00, "R11");
        rd(OFS, 8'h08, "R11");
        pulse(1, 2'b10, 0, 0); eng_busy = 0;
        rd(OFS, 8'h82, "R7");
        wr(OFS, 8'h01);
        rd(OFS, 8'h82, "R6");
        wr(OFS, 8'h02);
        rd(OFS, 8'h80, "R6");
        pulse(1, 2'b11, 0, 0);
        rd(OFS, 8'h80, "R7");

        // launch clears status bits
        wr(OFS, 8'h80); pulse(1, 2'b01, 0, 0);
        rd(OFS, 8'h81, "R7");
        wr(OFS, 8'h80);
        check({7'd0, cmd_start}, 8'h01, "R2");
        rd(OFS, 8'h00, "R2");
        pulse(1, 2'b00, 0, 0);

        // access error flag
        pulse(0, 0, 1, 0);
        rd(OFS, 8'hA0, "R5");
        wr(OFS, 8'h80);
        check({7'd0, cmd_start}, 8'h00, "R3");
        rd(OFS, 8'hA0, "R3");
        wr(OFS, 8'h00);
        rd(OFS, 8'hA0, "R6");
        wr(OFS, 8'h20, 1'b1, 1'b0);
        rd(OFS, 8'hA0, "R6");
        wr(OFS, 8'h20);
        rd(OFS, 8'h80, "R6");

        // protection flag
        pulse(0, 0, 0, 1);
        rd(OFS, 8'h90, "R5");
        wr(OFS, 8'h80);
        check({7'd0, cmd_start}, 8'h00, "R4");
        rd(OFS, 8'h90, "R4");
        wr(OFS, 8'h10);
        rd(OFS, 8'h80, "R6");

        // violation coinciding with the launch write
        wr(OFS, 8'h80, 1'b0, 1'b1);
        check({7'd0, cmd_start}, 8'h00, "R5");
        rd(OFS, 8'h90, "R5");
        wr(OFS, 8'h10);
        wr(OFS, 8'h80, 1'b1, 1'b0);
        check({7'd0, cmd_start}, 8'h00, "R5");
        rd(OFS, 8'hA0, "R5");
        wr(OFS, 8'h20);

        // violation ends a running command
        wr(OFS, 8'h80);
        check({7'd0, cmd_start}, 8'h01, "R2");
        pulse(0, 0, 1, 0);
        rd(OFS, 8'hA0, "R8");
        wr(OFS, 8'h20);

        // other addresses
        rd(OFS[AW-1:0] + 1'b1, 8'h00, "R10");
        wr(OFS[AW-1:0] + 1'b1, 8'h80);
        check({7'd0, cmd_start}, 8'h00, "R10");
        rd(OFS, 8'h80, "R10");

        repeat (3) @(posedge clk);
        report();
    end
endmodule